// File: doc/BRIEF.md
# Byte-Swapping Data FIFO Window

This block is a byte-wide data FIFO that sits between a host register window and a card-side transfer engine. The host sees it as a 32-bit window, and each word is big-endian: the first byte of the stream sits in bits 31:24. The card side sees a plain byte stream. A transfer is set up with a start pulse that latches the direction and the transfer length in bytes. In host-to-card mode the host fills the FIFO and the card engine drains it. In card-to-host mode the card engine fills it and the host drains it.

The host reaches the FIFO in two ways. One is programmed word accesses. The other is a block-move port, which is honoured only when the programmed length is a full buffer. The block tracks its occupancy and reports an empty flag. It keeps a sticky underrun flag for host reads of an empty FIFO. When the card engine signals the end of a transfer, it sets a sticky mismatch flag if the bytes moved on the card side differ from the programmed length. A controller reset input empties the FIFO and restores the defaults: card-to-host direction, zero length and clear flags.

Top module: `byteswap_fifo_window`

## Requirements
- R1: The FIFO holds up to DEPTH (default 512) bytes, and `level` never exceeds DEPTH. A host word written while the FIFO is full is dropped.
- R2: Host words are big-endian. In host-to-card mode, bits 31:24 of a written word reach the card first and bits 7:0 reach it last. In card-to-host mode, the oldest byte appears on `host_rdata[31:24]`.
- R3: `empty` is 1 exactly when `level` is 0.
- R4: In card-to-host mode, a host read (word access, or an honoured block beat) of an empty FIFO sets the sticky `underrun` flag. While the FIFO is empty, `host_rdata` is zero. That read leaves `level` unchanged.
- R5: A `done` pulse sets `mismatch` to 1 when the number of card-side bytes moved since `start` differs from the programmed length, and to 0 otherwise. A `start` pulse clears `mismatch` and `underrun`.
- R6: `dma_ok` is 1 only when the programmed length equals DEPTH. Block-port beats (`dma_wr_en`, `dma_rd_en`) have no effect while `dma_ok` is 0.
- R7: `start_dir` = 1 selects host-to-card mode and 0 selects card-to-host mode. In host-to-card mode, host reads and card pushes are ignored. In card-to-host mode, host writes and card pops are ignored.
- R8: In host-to-card mode, the final word of a transfer stores only the bytes that remain of the programmed length, taken from the high end of the word. In card-to-host mode, a host read with fewer than 4 bytes present returns them in the high lanes with zeros in the low lanes, and consumes only those bytes.
- R9: `soft_rst` empties the FIFO, clears both flags and restores card-to-host mode with length 0.
- R10: Host-to-card words written after the programmed length has been reached store no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Controller reset: empties the FIFO and restores defaults |
| start | input | 1 | Latches direction and length, clears counters and flags |
| start_dir | input | 1 | 1 = host-to-card, 0 = card-to-host |
| start_len | input | CW (10) | Transfer length in bytes |
| done | input | 1 | End of transfer from the card engine |
| pio_wr_en | input | 1 | Host word write |
| pio_wdata | input | 32 | Host write word, big-endian |
| pio_rd_en | input | 1 | Host word read (consumes the word shown on host_rdata) |
| host_rdata | output | 32 | Next host word, big-endian, zero-padded |
| dma_wr_en | input | 1 | Block-port word write |
| dma_wdata | input | 32 | Block-port write word |
| dma_rd_en | input | 1 | Block-port word read |
| dma_ok | output | 1 | Block port usable (length is a full buffer) |
| card_wr_en | input | 1 | Card pushes a byte |
| card_wdata | input | 8 | Card byte in |
| card_rd_en | input | 1 | Card pops a byte |
| card_rdata | output | 8 | Byte at the FIFO head |
| card_avail | output | 1 | A byte is available to the card |
| level | output | CW (10) | Occupancy in bytes |
| empty | output | 1 | FIFO holds no data |
| underrun | output | 1 | Sticky: host read while empty |
| mismatch | output | 1 | Sticky: card byte count differed from length |

## Verification
The host-to-card path is driven with lengths of one to four bytes and with distinct word values. Each byte that arrives at the card is compared against its lane, so that a reversed lane order, a lost padding rule and a miscounted tail each show up. The card-to-host path uses a six-byte stream, which tells a full-word read apart from a partial tail read. Directed cases cover a short transfer against a full-buffer one on the block port, an empty read against a normal read, a count that ends short against one that matches, and a controller reset with data and flags present.

// File: rtl/mfw_pkg.sv
package mfw_pkg;

    // Transfer direction as latched by a start pulse (bit value is the encoding).
    typedef enum logic {
        DIR_TO_HOST = 1'b0,
        DIR_TO_CARD = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/mfw_store.sv
// Byte storage with WB write lanes and WB read lanes at consecutive addresses.
module mfw_store #(
    parameter int DEPTH = 512,
    parameter int WB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = WB * 8
) (
    input  logic          clk,
    input  logic [WB-1:0] wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WB; i++) begin
            if (wr_en[i]) begin
                mem[wr_addr + AW'(i)] <= wr_data[i*8 +: 8];
            end
        end
    end

    for (genvar g = 0; g < WB; g++) begin : g_rd
        assign rd_data[g*8 +: 8] = mem[rd_addr + AW'(g)];
    end

endmodule

// File: rtl/mfw_lanes.sv
// Maps big-endian host words onto stream-ordered byte lanes (lane 0 = first byte).
module mfw_lanes #(
    parameter int WB  = 4,
    parameter int CW  = 10,
    localparam int PW = $clog2(WB + 1),
    localparam int DW = WB * 8
) (
    input  logic [CW-1:0] budget,   // bytes still allowed into the FIFO by length
    input  logic [CW-1:0] avail,    // bytes present in the FIFO
    input  logic [DW-1:0] wr_word,
    input  logic [DW-1:0] rd_bytes,
    output logic [PW-1:0] push_n,
    output logic [DW-1:0] wr_bytes,
    output logic [PW-1:0] pop_n,
    output logic [DW-1:0] rd_word
);

    assign push_n = (budget >= CW'(WB)) ? PW'(WB) : PW'(budget);
    assign pop_n  = (avail  >= CW'(WB)) ? PW'(WB) : PW'(avail);

    for (genvar g = 0; g < WB; g++) begin : g_lane
        assign wr_bytes[g*8 +: 8]     = wr_word[DW-1-g*8 -: 8];
        assign rd_word[DW-1-g*8 -: 8] = (PW'(g) < pop_n) ? rd_bytes[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/byteswap_fifo_window.sv
module byteswap_fifo_window
    import mfw_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int DW   = WB * 8,
    localparam int PW   = $clog2(WB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          start,
    input  logic          start_dir,
    input  logic [CW-1:0] start_len,
    input  logic          done,
    input  logic          pio_wr_en,
    input  logic [DW-1:0] pio_wdata,
    input  logic          pio_rd_en,
    output logic [DW-1:0] host_rdata,
    input  logic          dma_wr_en,
    input  logic [DW-1:0] dma_wdata,
    input  logic          dma_rd_en,
    output logic          dma_ok,
    input  logic          card_wr_en,
    input  logic [7:0]    card_wdata,
    input  logic          card_rd_en,
    output logic [7:0]    card_rdata,
    output logic          card_avail,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          underrun,
    output logic          mismatch
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [CW-1:0] len;
        logic [CW-1:0] hcnt;     // bytes accepted from the host this transfer
        logic [CW-1:0] moved;    // bytes moved on the card side this transfer
        xfer_dir_e     dir;
        logic          underrun;
        logic          mismatch;
    } state_t;

    state_t st_q, st_d;

    logic          host_wr, host_rd, to_card;
    logic [DW-1:0] host_wword;
    logic [PW-1:0] push_n, pop_n;
    logic [DW-1:0] wr_bytes, rd_bytes;
    logic          do_hpush, do_hpop, do_cpush, do_cpop, rd_empty;
    logic [WB-1:0] st_wr_en;
    logic [DW-1:0] st_wr_data;

    assign to_card    = (st_q.dir == DIR_TO_CARD);
    assign dma_ok     = (st_q.len == CW'(DEPTH));
    assign host_wr    = pio_wr_en | (dma_wr_en & dma_ok);
    assign host_rd    = pio_rd_en | (dma_rd_en & dma_ok);
    assign host_wword = pio_wr_en ? pio_wdata : dma_wdata;

    mfw_lanes #(.WB(WB), .CW(CW)) u_lanes (
        .budget   (st_q.len - st_q.hcnt),
        .avail    (st_q.count),
        .wr_word  (host_wword),
        .rd_bytes (rd_bytes),
        .push_n   (push_n),
        .wr_bytes (wr_bytes),
        .pop_n    (pop_n),
        .rd_word  (host_rdata)
    );

    assign do_hpush = to_card & host_wr & (push_n != '0)
                    & (CW'(push_n) <= (CW'(DEPTH) - st_q.count));
    assign do_cpop  = to_card & card_rd_en & (st_q.count != '0);
    assign do_cpush = !to_card & card_wr_en & (st_q.count != CW'(DEPTH));
    assign do_hpop  = !to_card & host_rd & (st_q.count != '0);
    assign rd_empty = !to_card & host_rd & (st_q.count == '0);

    always_comb begin
        for (int i = 0; i < WB; i++) begin
            st_wr_en[i] = to_card ? (do_hpush && (PW'(i) < push_n)) : ((i == 0) && do_cpush);
        end
        st_wr_data = to_card ? wr_bytes : {{(DW-8){1'b0}}, card_wdata};
    end

    mfw_store #(.DEPTH(DEPTH), .WB(WB)) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_addr (st_q.wr_ptr),
        .wr_data (st_wr_data),
        .rd_addr (st_q.rd_ptr),
        .rd_data (rd_bytes)
    );

    always_comb begin
        st_d = st_q;
        if (do_hpush) begin
            st_d.wr_ptr = st_q.wr_ptr + AW'(push_n);
            st_d.hcnt   = st_q.hcnt + CW'(push_n);
        end
        if (do_cpush) begin
            st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            st_d.moved  = st_q.moved + CW'(1);
        end
        if (do_hpop) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(pop_n);
        end
        if (do_cpop) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            st_d.moved  = st_q.moved + CW'(1);
        end
        st_d.count = st_q.count
                   + (do_hpush ? CW'(push_n) : '0) + CW'(do_cpush)
                   - (do_hpop ? CW'(pop_n) : '0) - CW'(do_cpop);
        if (rd_empty) begin
            st_d.underrun = 1'b1;
        end
        if (done) begin
            st_d.mismatch = (st_q.moved != st_q.len);
        end
        if (start) begin
            st_d.len      = start_len;
            st_d.dir      = xfer_dir_e'(start_dir);
            st_d.hcnt     = '0;
            st_d.moved    = '0;
            st_d.underrun = 1'b0;
            st_d.mismatch = 1'b0;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_rdata = rd_bytes[7:0];
    assign card_avail = to_card & (st_q.count != '0);
    assign level      = st_q.count;
    assign empty      = (st_q.count == '0);
    assign underrun   = st_q.underrun;
    assign mismatch   = st_q.mismatch;

    // R1
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R4
    empty_read_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_rd_en && !to_card && st_q.count == '0 && !card_wr_en && !start && !soft_rst)
        |=> (st_q.underrun && st_q.count == '0));

    // R6
    short_block_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_en && !dma_ok && !pio_wr_en && !card_wr_en && !start && !soft_rst)
        |=> $stable(st_q.wr_ptr));

    // R9
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.count == '0 && !st_q.underrun && !st_q.mismatch
                      && st_q.len == '0 && st_q.dir == DIR_TO_HOST));

    // R10
    host_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_TO_CARD) |-> (st_q.hcnt <= st_q.len));

endmodule

// File: tb/byteswap_fifo_window_test.sv
`timescale 1ns/1ps
module byteswap_fifo_window_test;

    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 0, start = 0, start_dir = 0, done = 0;
    logic [CW-1:0] start_len = '0;
    logic          pio_wr_en = 0, pio_rd_en = 0, dma_wr_en = 0, dma_rd_en = 0;
    logic [31:0]   pio_wdata = '0, dma_wdata = '0;
    logic [31:0]   host_rdata;
    logic          dma_ok, card_avail, empty, underrun, mismatch;
    logic          card_wr_en = 0, card_rd_en = 0;
    logic [7:0]    card_wdata = '0, card_rdata;
    logic [CW-1:0] level;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    byteswap_fifo_window uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
        .start_dir(start_dir), .start_len(start_len), .done(done),
        .pio_wr_en(pio_wr_en), .pio_wdata(pio_wdata), .pio_rd_en(pio_rd_en),
        .host_rdata(host_rdata), .dma_wr_en(dma_wr_en), .dma_wdata(dma_wdata),
        .dma_rd_en(dma_rd_en), .dma_ok(dma_ok), .card_wr_en(card_wr_en),
        .card_wdata(card_wdata), .card_rd_en(card_rd_en), .card_rdata(card_rdata),
        .card_avail(card_avail), .level(level), .empty(empty),
        .underrun(underrun), .mismatch(mismatch)
    );

    // Host-to-card vectors: length, written word, expected card byte stream (first byte high).
    localparam int NV = 5;
    localparam logic [2:0]  V_LEN  [NV] = '{3'd4, 3'd3, 3'd2, 3'd1, 3'd4};
    localparam logic [31:0] V_WORD [NV] = '{32'hA1B2C3D4, 32'h11223344, 32'hDEADBEEF,
                                           32'h5A667788, 32'h01020304};
    localparam logic [31:0] V_EXP  [NV] = '{32'hA1B2C3D4, 32'h11223300, 32'hDEAD0000,
                                           32'h5A000000, 32'h01020304};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic start_xfer(input logic d, input int len);
        start = 1; start_dir = d; start_len = CW'(len);
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_done();
        done = 1; @(negedge clk); done = 0;
    endtask

    task automatic host_write(input logic [31:0] w);
        pio_wdata = w; pio_wr_en = 1; @(negedge clk); pio_wr_en = 0;
    endtask

    task automatic host_read(output logic [31:0] w);
        w = host_rdata; pio_rd_en = 1; @(negedge clk); pio_rd_en = 0;
    endtask

    task automatic block_write(input logic [31:0] w);
        dma_wdata = w; dma_wr_en = 1; @(negedge clk); dma_wr_en = 0;
    endtask

    task automatic card_push(input logic [7:0] b);
        card_wdata = b; card_wr_en = 1; @(negedge clk); card_wr_en = 0;
    endtask

    task automatic card_pop(output logic [7:0] b);
        b = card_rdata; card_rd_en = 1; @(negedge clk); card_rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        int          errs;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state (R3, R9)
        chk("R3 reset level", 32'(level), 32'd0);
        chk("R3 reset empty", 32'(empty), 32'd1);
        chk("R9 reset underrun", 32'(underrun), 32'd0);
        chk("R9 reset mismatch", 32'(mismatch), 32'd0);
        chk("R6 reset dma_ok", 32'(dma_ok), 32'd0);

        // Table walk: host-to-card words with short lengths
        for (int v = 0; v < NV; v++) begin
            start_xfer(1'b1, int'(V_LEN[v]));
            host_write(V_WORD[v]);
            chk("R8 stored bytes", 32'(level), 32'(V_LEN[v]));
            host_write(32'hFFFFFFFF);
            chk("R10 extra word ignored", 32'(level), 32'(V_LEN[v]));
            chk("R7 card_avail", 32'(card_avail), 32'd1);
            for (int j = 0; j < int'(V_LEN[v]); j++) begin
                card_pop(b);
                chk("R2 byte order", 32'(b), 32'(V_EXP[v][31-8*j -: 8]));
            end
            chk("R3 drained empty", 32'(empty), 32'd1);
            pulse_done();
            chk("R5 exact count no mismatch", 32'(mismatch), 32'd0);
        end

        // Card-to-host: 6 bytes, full word then partial tail
        start_xfer(1'b0, 6);
        host_write(32'hCAFEF00D);
        chk("R7 host write ignored in read mode", 32'(level), 32'd0);
        for (int k = 0; k < 6; k++) card_push(8'(8'h10 + k));
        chk("R7 card push level", 32'(level), 32'd6);
        card_rd_en = 1; @(negedge clk); card_rd_en = 0;
        chk("R7 card pop ignored in read mode", 32'(level), 32'd6);
        host_read(w);
        chk("R2 host word order", w, 32'h10111213);
        chk("R8 level after word", 32'(level), 32'd2);
        host_read(w);
        chk("R8 partial tail padding", w, 32'h14150000);
        chk("R3 empty after tail", 32'(empty), 32'd1);
        pulse_done();
        chk("R5 read count match", 32'(mismatch), 32'd0);

        // Underrun
        chk("R4 zero data when empty", host_rdata, 32'h0);
        host_read(w);
        chk("R4 underrun set", 32'(underrun), 32'd1);
        chk("R4 level unchanged", 32'(level), 32'd0);
        card_push(8'hAB);
        chk("R4 level after push", 32'(level), 32'd1);
        host_read(w);
        chk("R4 data after underrun", w, 32'hAB000000);
        chk("R4 underrun sticky", 32'(underrun), 32'd1);

        // Mismatch
        start_xfer(1'b1, 8);
        chk("R5 start clears underrun", 32'(underrun), 32'd0);
        host_write(32'h01020304);
        host_write(32'h05060708);
        for (int k = 0; k < 5; k++) card_pop(b);
        pulse_done();
        chk("R5 short count mismatch", 32'(mismatch), 32'd1);
        start_xfer(1'b1, 8);
        chk("R5 start clears mismatch", 32'(mismatch), 32'd0);
        soft_rst = 1; @(negedge clk); soft_rst = 0;

        // Block port
        start_xfer(1'b1, 100);
        chk("R6 short length refused", 32'(dma_ok), 32'd0);
        block_write(32'h11111111);
        chk("R6 short block beat ignored", 32'(level), 32'd0);
        start_xfer(1'b1, 512);
        chk("R6 full length accepted", 32'(dma_ok), 32'd1);
        for (int i = 0; i < 128; i++)
            block_write({8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        chk("R1 full capacity", 32'(level), 32'd512);
        host_write(32'hEEEEEEEE);
        chk("R1 write when full dropped", 32'(level), 32'd512);
        errs = 0;
        for (int n = 0; n < 512; n++) begin
            card_pop(b);
            if (b !== 8'(n)) errs++;
        end
        chk("R1 full block stream", 32'(errs), 32'd0);
        pulse_done();
        chk("R5 full block count", 32'(mismatch), 32'd0);

        start_xfer(1'b0, 8);
        for (int k = 0; k < 8; k++) card_push(8'(k));
        dma_rd_en = 1; @(negedge clk); dma_rd_en = 0;
        chk("R6 short block read ignored", 32'(level), 32'd8);
        host_read(w);
        chk("R6 word read after refusal", 32'(level), 32'd4);

        // Controller reset with data and flags present
        host_read(w);
        host_read(w);
        chk("R4 underrun before reset", 32'(underrun), 32'd1);
        card_push(8'h77);
        soft_rst = 1; @(negedge clk); soft_rst = 0;
        chk("R9 level cleared", 32'(level), 32'd0);
        chk("R9 underrun cleared", 32'(underrun), 32'd0);
        chk("R9 length default", 32'(dma_ok), 32'd0);
        card_push(8'h42);
        chk("R9 default read direction", 32'(level), 32'd1);
        chk("R9 host word after reset", host_rdata, 32'h42000000);

        finished = 1;
        summary();
        $finish;
    end

endmodule